// File: doc/BRIEF.md
# Recursive Resonator FSK Tone Generator

This block produces a two-tone frequency-shift-keyed sample stream for a modem that shares a current-loop line with an analog signal. It has no sine table and no phase accumulator. Each output sample comes from a two-pole recursive resonator: one multiply by a tone coefficient, then one subtraction of the older state. A one bit selects the 1200 Hz tone and a zero bit selects the 2200 Hz tone, both at an 8 kHz sample rate. Two coefficients and two start-up excitation values are held as constants. The right pair is chosen from the bit being sent.

A sample strobe (`sample_tick`) paces the block. Every strobe yields one signed Q1.14 sample one clock later. Data bits arrive over a valid/ready handshake. A bit occupies a fixed number of strobes, and the next bit is taken only on the first strobe of a new bit period. The sender must hold `bit_valid` and `bit_data` until a transfer occurs; `bit_ready` rises only during a boundary strobe, and a transfer is the clock edge on which both are high. The block applies no other back-pressure. If no bit is offered at a boundary, the output goes silent until a bit arrives.

When the tone changes, or when sending starts from silence, the resonator state is re-seeded: the newer state is cleared and the older state is loaded with the new tone's excitation value, so the new tone starts at phase zero. When consecutive bits use the same tone, the resonator simply keeps running, with no phase jump.

Top module: `fsk_tone_gen`

## Requirements
- R1: On each strobe of an active bit, the next sample is X0 = sat(floor((k·X1 + 8192) / 16384) − X2), after which X2 takes the old X1 and X1 takes X0. Samples are signed 16-bit Q1.14 and k is signed 16-bit Q2.14.
- R2: A bit value 1 uses k = 19261 (2·cos(2π·1200/8000)) and a bit value 0 uses k = −5126 (2·cos(2π·2200/8000)).
- R3: When a bit is accepted from silence, or with a tone different from the previous bit, X1 is taken as 0 and X2 as the tone's seed (−6627 for bit 1, −8091 for bit 0) before computing, so the first sample equals the negated seed.
- R4: When an accepted bit has the same tone as the previous active bit, the state is not re-seeded and the waveform continues from the previous samples.
- R5: A bit lasts exactly SAMPLES_PER_BIT strobes (default 7). `bit_ready` is high only while `sample_tick` is high on the first strobe of a bit period; `bit_valid`/`bit_data` on all other strobes are ignored.
- R6: If `bit_valid` is low at a boundary strobe, that strobe yields sample 0, the state is cleared, every later strobe is a boundary, and the next accepted bit is re-seeded.
- R7: The resonator result is saturated to [−32768, 32767] before it is output and stored.
- R8: `sample_valid` is high for exactly the one clock after each strobe. `sample_out` changes only together with `sample_valid`.
- R9: After reset `sample_out` is 0, `sample_valid` is 0, the block is silent, and the next strobe is a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-clock strobe per output sample (8 kHz rate) |
| bit_valid | input | 1 | A data bit is offered |
| bit_data | input | 1 | Offered bit: 1 selects 1200 Hz, 0 selects 2200 Hz |
| bit_ready | output | 1 | High during a boundary strobe; a transfer needs this and bit_valid |
| sample_valid | output | 1 | New sample on sample_out this cycle |
| sample_out | output | 16 | Signed Q1.14 sample |

## Verification
The bench targets several corner cases:
- The re-seed decision. Every change between tones, and every start from silence, must restart at the negated seed, while a repeated tone must continue without re-seeding. A design that re-seeds on every bit, or never re-seeds, drifts from the reference samples at the first boundary.
- Bit edges toggled in the middle of a bit period. These catch a design that samples the bit on the wrong strobe or raises ready outside a boundary.
- A second instance with an oversized seed. It pushes the recurrence past full scale, and a missing clamp would wrap to a large negative value.
- Gaps with no valid bit, followed by a reset in mid-bit. These show whether the state is cleared and the next start is seeded again.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;
  typedef enum logic {
    TONE_SPACE = 1'b0,
    TONE_MARK  = 1'b1
  } tone_e;

  localparam int NUM_TONES      = 2;
  localparam int DEF_SAMPLE_W   = 16;
  localparam int DEF_FRAC_W     = 14;
  // 2*cos(2*pi*f/8000) in Q2.14
  localparam int DEF_K_MARK     = 19261;
  localparam int DEF_K_SPACE    = -5126;
  // -0.5*sin(2*pi*f/8000) in Q1.14
  localparam int DEF_SEED_MARK  = -6627;
  localparam int DEF_SEED_SPACE = -8091;
endpackage

// File: rtl/fsk_bit_pacer.sv
module fsk_bit_pacer
  import fsk_tone_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sample_tick,
  input  logic  bit_valid,
  input  logic  bit_data,
  output logic  bit_ready,
  output logic  run,
  output logic  reseed,
  output tone_e tone
);
  localparam int CNT_W = (SAMPLES_PER_BIT > 1) ? $clog2(SAMPLES_PER_BIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SAMPLES_PER_BIT - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             active_q;
  tone_e            tone_q;
  logic             boundary;
  logic             take;
  tone_e            offered;

  always_comb begin
    boundary  = (cnt_q == '0);
    offered   = tone_e'(bit_data);
    bit_ready = sample_tick && boundary;
    take      = bit_ready && bit_valid;
    tone      = take ? offered : tone_q;
    run       = sample_tick && (boundary ? bit_valid : active_q);
    reseed    = take && (!active_q || (offered != tone_q));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      tone_q   <= TONE_SPACE;
    end else if (sample_tick) begin
      if (boundary) begin
        if (bit_valid) begin
          active_q <= 1'b1;
          tone_q   <= offered;
          cnt_q    <= LAST;
        end else begin
          active_q <= 1'b0;
        end
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  // R5: the position counter never leaves its bit window
  p_cnt_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R5: bit and position move only on strobes
  p_steady_between_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_tick |=> ($stable(tone_q) && $stable(cnt_q)));

  // R6: a silent pacer sits on a boundary
  p_idle_on_boundary_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (cnt_q == '0));
endmodule

// File: rtl/fsk_coef_rom.sv
module fsk_coef_rom
  import fsk_tone_pkg::*;
#(
  parameter int SAMPLE_W   = DEF_SAMPLE_W,
  parameter int K_W        = DEF_SAMPLE_W,
  parameter int K_MARK     = DEF_K_MARK,
  parameter int K_SPACE    = DEF_K_SPACE,
  parameter int SEED_MARK  = DEF_SEED_MARK,
  parameter int SEED_SPACE = DEF_SEED_SPACE
) (
  input  tone_e                      tone,
  output logic signed [K_W-1:0]      k_coef,
  output logic signed [SAMPLE_W-1:0] seed_val
);
  logic signed [K_W-1:0]      k_tab    [NUM_TONES];
  logic signed [SAMPLE_W-1:0] seed_tab [NUM_TONES];

  for (genvar g = 0; g < NUM_TONES; g++) begin : g_entry
    if (g == int'(TONE_MARK)) begin : g_mark
      assign k_tab[g]    = K_W'(K_MARK);
      assign seed_tab[g] = SAMPLE_W'(SEED_MARK);
    end else begin : g_space
      assign k_tab[g]    = K_W'(K_SPACE);
      assign seed_tab[g] = SAMPLE_W'(SEED_SPACE);
    end
  end

  always_comb begin
    k_coef   = k_tab[tone];
    seed_val = seed_tab[tone];
  end
endmodule

// File: rtl/fsk_resonator.sv
module fsk_resonator #(
  parameter int SAMPLE_W = 16,
  parameter int FRAC_W   = 14,
  parameter int K_W      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_tick,
  input  logic                       run,
  input  logic                       reseed,
  input  logic signed [K_W-1:0]      k_coef,
  input  logic signed [SAMPLE_W-1:0] seed_val,
  output logic                       sample_valid,
  output logic signed [SAMPLE_W-1:0] sample_out
);
  localparam int PROD_W = K_W + SAMPLE_W;
  localparam int ACC_W  = PROD_W + 2;
  localparam logic signed [ACC_W-1:0] ROUND_C = ACC_W'(longint'(1) <<< (FRAC_W - 1));
  localparam logic signed [ACC_W-1:0] MAX_V   = ACC_W'((longint'(1) <<< (SAMPLE_W - 1)) - 1);
  localparam logic signed [ACC_W-1:0] MIN_V   = ACC_W'(-(longint'(1) <<< (SAMPLE_W - 1)));

  logic signed [SAMPLE_W-1:0] x1_q, x2_q;
  logic signed [SAMPLE_W-1:0] x1_eff, x2_eff, x0;
  logic signed [PROD_W-1:0]   prod;
  logic signed [ACC_W-1:0]    rnd, diff;

  always_comb begin
    x1_eff = reseed ? '0 : x1_q;
    x2_eff = reseed ? seed_val : x2_q;
    prod   = k_coef * x1_eff;
    rnd    = ($signed({{2{prod[PROD_W-1]}}, prod}) + ROUND_C) >>> FRAC_W;
    diff   = rnd - $signed({{(ACC_W-SAMPLE_W){x2_eff[SAMPLE_W-1]}}, x2_eff});
    if (diff > MAX_V)      x0 = MAX_V[SAMPLE_W-1:0];
    else if (diff < MIN_V) x0 = MIN_V[SAMPLE_W-1:0];
    else                   x0 = diff[SAMPLE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x1_q         <= '0;
      x2_q         <= '0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      sample_valid <= sample_tick;
      if (sample_tick) begin
        if (run) begin
          x2_q       <= x1_eff;
          x1_q       <= x0;
          sample_out <= x0;
        end else begin
          x1_q       <= '0;
          x2_q       <= '0;
          sample_out <= '0;
        end
      end
    end
  end

  // R8: each strobe yields a valid pulse on the next clock
  p_valid_after_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sample_tick |=> sample_valid);

  // R8: output holds when no sample is being presented
  p_hold_without_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_valid |-> $stable(sample_out));

  // R3: a re-seeded strobe outputs the negated seed
  p_seed_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && run && reseed && (seed_val != MIN_V[SAMPLE_W-1:0]))
      |=> (sample_out == -$past(seed_val)));

  // R6: a silent strobe outputs zero
  p_silent_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_tick && !run) |=> (sample_out == '0));
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen
  import fsk_tone_pkg::*;
#(
  parameter int SAMPLE_W        = DEF_SAMPLE_W,
  parameter int FRAC_W          = DEF_FRAC_W,
  parameter int K_W             = DEF_SAMPLE_W,
  parameter int SAMPLES_PER_BIT = 7,
  parameter int K_MARK          = DEF_K_MARK,
  parameter int K_SPACE         = DEF_K_SPACE,
  parameter int SEED_MARK       = DEF_SEED_MARK,
  parameter int SEED_SPACE      = DEF_SEED_SPACE
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sample_tick,
  input  logic                       bit_valid,
  input  logic                       bit_data,
  output logic                       bit_ready,
  output logic                       sample_valid,
  output logic signed [SAMPLE_W-1:0] sample_out
);
  logic                       run, reseed;
  tone_e                      tone;
  logic signed [K_W-1:0]      k_coef;
  logic signed [SAMPLE_W-1:0] seed_val;

  fsk_bit_pacer #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT)
  ) u_pacer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .bit_valid  (bit_valid),
    .bit_data   (bit_data),
    .bit_ready  (bit_ready),
    .run        (run),
    .reseed     (reseed),
    .tone       (tone)
  );

  fsk_coef_rom #(
    .SAMPLE_W  (SAMPLE_W),
    .K_W       (K_W),
    .K_MARK    (K_MARK),
    .K_SPACE   (K_SPACE),
    .SEED_MARK (SEED_MARK),
    .SEED_SPACE(SEED_SPACE)
  ) u_rom (
    .tone    (tone),
    .k_coef  (k_coef),
    .seed_val(seed_val)
  );

  fsk_resonator #(
    .SAMPLE_W(SAMPLE_W),
    .FRAC_W  (FRAC_W),
    .K_W     (K_W)
  ) u_res (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_tick (sample_tick),
    .run         (run),
    .reseed      (reseed),
    .k_coef      (k_coef),
    .seed_val    (seed_val),
    .sample_valid(sample_valid),
    .sample_out  (sample_out)
  );

  // R5: ready is only offered on a strobe
  p_ready_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |-> sample_tick);
endmodule

// File: tb/fsk_tone_gen_tb.sv
module fsk_tone_gen_tb;
  localparam int SPB = 7;
  localparam int NV  = 12;
  // {valid, data}
  localparam logic [1:0] VEC [NV] = '{2'b11, 2'b11, 2'b10, 2'b10, 2'b11, 2'b00,
                                      2'b10, 2'b11, 2'b11, 2'b00, 2'b11, 2'b10};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, sample_valid, sat_ready, sat_valid;
  logic signed [15:0] sample_out, sat_out;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  int m_x1 [2], m_x2 [2], m_cnt [2];
  bit m_act [2], m_bit [2];
  int seed_mark [2] = '{-6627, -30000};

  always #10 clk = ~clk;

  fsk_tone_gen #(.SAMPLES_PER_BIT(SPB)) u_dut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .sample_valid(sample_valid), .sample_out(sample_out));

  fsk_tone_gen #(.SAMPLES_PER_BIT(SPB), .SEED_MARK(-30000)) u_sat (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick),
    .bit_valid(1'b1), .bit_data(1'b1), .bit_ready(sat_ready),
    .sample_valid(sat_valid), .sample_out(sat_out));

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_x1[i] = 0; m_x2[i] = 0; m_cnt[i] = 0; m_act[i] = 0; m_bit[i] = 0;
    end
  endtask

  task automatic model_step(input int id, input bit v, input bit d,
                            output longint s, output bit rdy, output string tag);
    bit seed = 0;
    longint p, x0;
    int x1e, x2e, kk;
    rdy = (m_cnt[id] == 0);
    if (rdy) begin
      if (v) begin
        seed = !m_act[id] || (d != m_bit[id]);
        tag = seed ? "R3" : "R4";
        m_bit[id] = d; m_act[id] = 1; m_cnt[id] = SPB - 1;
      end else begin
        m_act[id] = 0; tag = "R6";
      end
    end else begin
      m_cnt[id]--;
      tag = m_bit[id] ? "R1" : "R2";
    end
    if (!m_act[id]) begin
      m_x1[id] = 0; m_x2[id] = 0; s = 0;
    end else begin
      x1e = seed ? 0 : m_x1[id];
      x2e = seed ? (m_bit[id] ? seed_mark[id] : -8091) : m_x2[id];
      kk  = m_bit[id] ? 19261 : -5126;
      p   = longint'(kk) * x1e;
      x0  = ((p + 8192) >>> 14) - x2e;
      if (x0 > 32767) x0 = 32767;
      if (x0 < -32768) x0 = -32768;
      m_x2[id] = x1e; m_x1[id] = int'(x0); s = x0;
    end
    if (id == 1) tag = "R7";
  endtask

  task automatic do_tick(input bit v, input bit d);
    longint s0, s1;
    bit r0, r1;
    string t0, t1;
    @(negedge clk);
    bit_valid = v; bit_data = d; sample_tick = 1'b1;
    model_step(0, v, d, s0, r0, t0);
    model_step(1, 1'b1, 1'b1, s1, r1, t1);
    #1;
    chk("R5 bit_ready", longint'(bit_ready), longint'(r0));
    @(negedge clk);
    sample_tick = 1'b0;
    chk("R8 sample_valid", longint'(sample_valid), 1);
    chk(t0, longint'(sample_out), s0);
    chk(t1, longint'(sat_out), s1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    longint held;
    model_reset();
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9 sample_out", longint'(sample_out), 0);
    chk("R9 sample_valid", longint'(sample_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 bit_ready idle", longint'(bit_ready), 0);

    for (int e = 0; e < NV; e++) begin
      if (!VEC[e][1]) begin
        do_tick(1'b0, VEC[e][0]);
      end else begin
        for (int j = 0; j < SPB; j++) begin
          if (j == 0) do_tick(1'b1, VEC[e][0]);
          else        do_tick(1'b1, ~VEC[e][0]); // R5: mid-bit offer ignored
        end
      end
    end

    // R8: output holds between strobes
    held = longint'(sample_out);
    repeat (2) @(negedge clk);
    chk("R8 valid low between ticks", longint'(sample_valid), 0);
    chk("R8 output held", longint'(sample_out), held);

    // R9: reset in mid-bit, then a fresh start is seeded
    do_tick(1'b1, 1'b1);
    do_tick(1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 out after reset", longint'(sample_out), 0);
    chk("R9 valid after reset", longint'(sample_valid), 0);
    rst_n = 1'b1;
    model_reset();
    for (int j = 0; j < SPB; j++) do_tick(1'b1, 1'b0);
    for (int j = 0; j < SPB; j++) do_tick(1'b1, 1'b0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule